// File: doc/BRIEF.md
# Serial Control Port with Register Read-back

This block is the serial control front end of a mixed-signal device. A host moves 14-bit words into the chip over a clock line (`sck`), a data line (`sdi`) and a load strobe (`load`). Every word is six address bits followed by eight data bits, both most significant bit first. A word whose address bit 4 is clear writes its data byte into one of 32 eight-bit control registers. A word whose address bit 4 is set asks for a read. Its data byte is a filler, and the register at the same address with bit 4 cleared is sent back to the host over the serial output.

The serial output has no pin of its own. It shares a pin with bit 9 of the device's parallel data output. The pin is driven only while the active-low output enable is low. During a read-back it carries the serial bit stream, but only while the output power-down bit in the register file is clear. At all other times it carries the parallel data bit. The returned byte is captured into its own output shift register when the read word is latched. The host can therefore clock the next word into `sdi` while the byte is still leaving the chip.

All serial inputs are sampled by the system clock `clk`, and edges are found by comparing each input with its value one clock earlier. `sck`, `sdi` and `load` must already be synchronous to `clk`, and each level must be held for at least two `clk` cycles.

Top module: `sif_ctrl_port`

## Requirements
- R1: `sdi` is sampled on each rising edge of `sck`. Of the 14 bits in a word, the first six are address bits a5..a0 and the last eight are data bits d7..d0, each group most significant bit first. The word takes effect on the rising edge of `load`.
- R2: When a5..a0 has bit a4 = 0, the write updates register index {a5,a3,a2,a1,a0}. That register appears on `cfg_flat[8*index+7 : 8*index]`, and no other register changes.
- R3: A read word (a4 = 1) changes no register. Its data byte is ignored.
- R4: A read word returns the register at index {a5,a3,a2,a1,a0}. From the cycle after the latch the pin shows d7. Each falling `sck` edge moves it on by one bit, so d0 shows after the seventh fall. After the eighth fall the pin returns to `pdata_bit`.
- R5: The returned byte is captured when the read word is latched. Words shifted in or latched while it is being sent, including a write to the same register, do not change the bits that leave the chip.
- R6: `pin_oe` is 1 exactly when `oe_n` is 0.
- R7: Bit 0 of register index 6 is the output power-down bit. While it is 1, the pin carries `pdata_bit` even during a read-back.
- R8: After reset every register is 0, no read-back is pending, and the pin carries `pdata_bit`.
- R9: A word takes effect only if exactly 14 `sck` rising edges came between the previous `load` rising edge (or reset) and this one. With 13 or 15 bits the word is dropped and the bit count starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sck | input | 1 | Serial bit clock from the host |
| sdi | input | 1 | Serial data in |
| load | input | 1 | Word latch strobe, acts on its rising edge |
| oe_n | input | 1 | Active-low enable for the shared pin driver |
| pdata_bit | input | 1 | Parallel output bit 9 that shares the pin |
| pin_out | output | 1 | Value driven onto the shared pin |
| pin_oe | output | 1 | Driver enable for the shared pin |
| cfg_flat | output | 256 | All 32 control registers, register i at bits 8*i+7..8*i |

## Verification
Edges of `sck` and `load` are seen one `clk` cycle after the input changes, and written registers and the read-back pin settle on the edge after that. The bench holds every serial level for two clock cycles and reads the design's outputs on falling `clk` edges two cycles after each stimulus. The bench reads each returned bit just before it raises `sck`, which is where the host would sample it. By then the previous falling edge has moved the shift register on. The check that the pin has gone back to `pdata_bit` is taken just before the ninth rising edge of the next word. Register contents are compared on `cfg_flat` against a model two cycles after each `load` pulse ends.

// File: rtl/sif_pkg.sv
`timescale 1ns/1ps
package sif_pkg;
  localparam int unsigned DEF_ADDR_W   = 6;
  localparam int unsigned DEF_DATA_W   = 8;
  localparam int unsigned DEF_RD_BIT   = 4;
  localparam int unsigned DEF_PD_INDEX = 6;
  localparam int unsigned DEF_PD_BIT   = 0;

  typedef enum logic [1:0] {
    WK_NONE  = 2'd0,
    WK_WRITE = 2'd1,
    WK_READ  = 2'd2
  } word_kind_e;
endpackage

// File: rtl/sif_edges.sv
`timescale 1ns/1ps
module sif_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic load,
  output logic sck_rise,
  output logic sck_fall,
  output logic load_rise
);
  logic sck_q, load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      load_q <= 1'b0;
    end else begin
      sck_q  <= sck;
      load_q <= load;
    end
  end

  assign sck_rise  = sck & ~sck_q;
  assign sck_fall  = ~sck & sck_q;
  assign load_rise = load & ~load_q;
endmodule

// File: rtl/sif_shift_in.sv
`timescale 1ns/1ps
module sif_shift_in #(
  parameter int unsigned FRAME_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck_rise,
  input  logic               sdi,
  input  logic               load_rise,
  output logic [FRAME_W-1:0] frame,
  output logic               frame_ok
);
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load_rise) begin
      cnt_d = '0;
    end else if (sck_rise) begin
      sh_d = {sh_q[FRAME_W-2:0], sdi};
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign frame    = sh_q;
  assign frame_ok = load_rise && (cnt_q == CNT_FULL);
endmodule

// File: rtl/sif_regfile.sv
`timescale 1ns/1ps
module sif_regfile #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [IDX_W-1:0]              widx,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [IDX_W-1:0]              ridx,
  output logic [DATA_W-1:0]             rdata,
  output logic [(1<<IDX_W)*DATA_W-1:0]  cfg_flat
);
  localparam int unsigned N_REGS = 1 << IDX_W;

  logic [DATA_W-1:0] regs [N_REGS];

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    logic              hit;
    logic [DATA_W-1:0] nxt;
    assign hit = we && (widx == IDX_W'(i));
    assign nxt = hit ? wdata : regs[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[i] <= '0;
      else        regs[i] <= nxt;
    end

    assign cfg_flat[i*DATA_W +: DATA_W] = regs[i];
  end

  assign rdata = regs[ridx];
endmodule

// File: rtl/sif_readback.sv
`timescale 1ns/1ps
module sif_readback #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] cap_val,
  input  logic              sck_fall,
  output logic              sdo,
  output logic              pend
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DATA_W);

  logic [DATA_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (cap_en) begin
      sr_d  = cap_val;
      cnt_d = CNT_LOAD;
    end else if (sck_fall && (cnt_q != '0)) begin
      sr_d  = {sr_q[DATA_W-2:0], 1'b0};
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign sdo  = sr_q[DATA_W-1];
  assign pend = (cnt_q != '0);
endmodule

// File: rtl/sif_ctrl_port.sv
`timescale 1ns/1ps
module sif_ctrl_port
  import sif_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned RD_BIT   = DEF_RD_BIT,
  parameter int unsigned PD_INDEX = DEF_PD_INDEX,
  parameter int unsigned PD_BIT   = DEF_PD_BIT,
  localparam int unsigned IDX_W   = ADDR_W - 1,
  localparam int unsigned FRAME_W = ADDR_W + DATA_W,
  localparam int unsigned CFG_W   = (1 << IDX_W) * DATA_W,
  localparam int unsigned PD_POS  = PD_INDEX * DATA_W + PD_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             sdi,
  input  logic             load,
  input  logic             oe_n,
  input  logic             pdata_bit,
  output logic             pin_out,
  output logic             pin_oe,
  output logic [CFG_W-1:0] cfg_flat
);
  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic sck_rise, sck_fall, load_rise;

  sif_edges u_edges (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sck       (sck),
    .load      (load),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .load_rise (load_rise)
  );

  logic [FRAME_W-1:0] frame;
  logic               frame_ok;

  sif_shift_in #(.FRAME_W(FRAME_W)) u_shift_in (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sck_rise  (sck_rise),
    .sdi       (sdi),
    .load_rise (load_rise),
    .frame     (frame),
    .frame_ok  (frame_ok)
  );

  // word decode
  logic [ADDR_W-1:0] w_addr;
  logic [DATA_W-1:0] w_data;
  logic [IDX_W-1:0]  w_idx;
  word_kind_e        w_kind;
  logic              we, rd_load;

  assign w_addr = frame[FRAME_W-1:DATA_W];
  assign w_data = frame[DATA_W-1:0];
  assign w_idx  = {w_addr[ADDR_W-1:RD_BIT+1], w_addr[RD_BIT-1:0]};

  always_comb begin
    w_kind = WK_NONE;
    if (frame_ok) w_kind = w_addr[RD_BIT] ? WK_READ : WK_WRITE;
  end

  assign we      = (w_kind == WK_WRITE);
  assign rd_load = (w_kind == WK_READ);

  logic [DATA_W-1:0] rd_val;

  sif_regfile #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_regfile (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .we       (we),
    .widx     (w_idx),
    .wdata    (w_data),
    .ridx     (w_idx),
    .rdata    (rd_val),
    .cfg_flat (cfg_flat)
  );

  logic rb_sdo, rb_pend;

  sif_readback #(.DATA_W(DATA_W)) u_readback (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cap_en   (rd_load),
    .cap_val  (rd_val),
    .sck_fall (sck_fall),
    .sdo      (rb_sdo),
    .pend     (rb_pend)
  );

  // shared pin
  logic pd_on;
  assign pd_on   = cfg_flat[PD_POS];
  assign pin_out = (rb_pend && !pd_on) ? rb_sdo : pdata_bit;
  assign pin_oe  = ~oe_n;
endmodule

// File: rtl/sif_ctrl_port_chk.sv
`timescale 1ns/1ps
module sif_ctrl_port_chk #(
  parameter int unsigned CFG_W  = 256,
  parameter int unsigned PD_POS = 48
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             sck_fall,
  input logic             we,
  input logic             rd_load,
  input logic             rb_pend,
  input logic             rb_sdo,
  input logic             pdata_bit,
  input logic             pin_out,
  input logic [CFG_W-1:0] cfg_flat
);
  // R2: registers change only on the edge after a write word
  p_cfg_only_on_write_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(cfg_flat) |-> $past(we));

  // R3: a read word leaves every register as it was
  p_read_keeps_cfg_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_load |=> $stable(cfg_flat));

  // R4: a latched read starts a pending read-back
  p_read_starts_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_load |=> rb_pend);

  // R4: read-back ends only on a falling sck edge
  p_read_ends_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(rb_pend) |-> $past(sck_fall));

  // R5: the outgoing bit holds between falling edges
  p_bit_holds_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (rb_pend && !sck_fall && !rd_load) |=> $stable(rb_sdo));

  // R7: power-down forces the parallel bit onto the pin
  p_pd_gates_pin_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_flat[PD_POS] |-> (pin_out == pdata_bit));
endmodule

bind sif_ctrl_port sif_ctrl_port_chk #(.CFG_W(CFG_W), .PD_POS(PD_POS)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .sck_fall  (sck_fall),
  .we        (we),
  .rd_load   (rd_load),
  .rb_pend   (rb_pend),
  .rb_sdo    (rb_sdo),
  .pdata_bit (pdata_bit),
  .pin_out   (pin_out),
  .cfg_flat  (cfg_flat)
);

// File: tb/sif_ctrl_port_bench.sv
`timescale 1ns/1ps
module sif_ctrl_port_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, sck, sdi, load, oe_n, pdata_bit, pin_out, pin_oe;
  logic [255:0] cfg_flat;

  sif_ctrl_port u_sif_ctrl_port (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .load(load),
    .oe_n(oe_n), .pdata_bit(pdata_bit), .pin_out(pin_out),
    .pin_oe(pin_oe), .cfg_flat(cfg_flat)
  );

  int errs = 0;
  int checks = 0;
  logic done = 1'b0;
  logic [7:0] mdl [32];

  function automatic logic [4:0] idx_of(input logic [5:0] a);
    return {a[5], a[3:0]};
  endfunction

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_cfg(input string tag);
    logic bad;
    bad = 1'b0;
    checks++;
    for (int i = 0; i < 32; i++) begin
      if (cfg_flat[i*8 +: 8] !== mdl[i]) begin
        bad = 1'b1;
        $display("FAIL %s reg %0d actual=%h expected=%h", tag, i, cfg_flat[i*8 +: 8], mdl[i]);
      end
    end
    if (bad) errs++;
  endtask

  // shifts nbits of {addr,data} MSB first, then pulses load
  task automatic xfer(input logic [5:0] a, input logic [7:0] d, input int nbits,
                      output logic [7:0] got, output logic after8);
    logic [15:0] v;
    v = {2'b00, a, d};
    got = 8'h00;
    after8 = 1'b0;
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk) sdi = v[nbits-1-k];
      repeat (2) @(negedge clk);
      if (k < 8) got[7-k] = pin_out;
      if (k == 8) after8 = pin_out;
      sck = 1'b1;
      repeat (2) @(negedge clk);
      sck = 1'b0;
    end
    repeat (2) @(negedge clk);
    load = 1'b1;
    repeat (2) @(negedge clk);
    load = 1'b0;
    repeat (2) @(negedge clk);
    if (nbits == 14 && !a[4]) mdl[idx_of(a)] = d;
  endtask

  task automatic t_reset();
    logic [7:0] g;
    logic a8;
    pdata_bit = 1'b0;
    @(negedge clk);
    chk8("R8 pin follows pdata 0 after reset", {7'd0, pin_out}, 8'h00);
    pdata_bit = 1'b1;
    @(negedge clk);
    chk8("R8 pin follows pdata 1 after reset", {7'd0, pin_out}, 8'h01);
    chk_cfg("R8 all registers zero after reset");
    xfer(6'b010011, 8'hFF, 14, g, a8);
    xfer(6'b010011, 8'h00, 14, g, a8);
    chk8("R8 read-back of reset register", g, 8'h00);
  endtask

  task automatic t_write();
    logic [7:0] g;
    logic a8;
    xfer(6'b000011, 8'h1E, 14, g, a8);
    chk8("R1 bit order of write word", cfg_flat[3*8 +: 8], 8'h1E);
    xfer(6'b100101, 8'hA5, 14, g, a8);
    chk8("R2 write to index 21", cfg_flat[21*8 +: 8], 8'hA5);
    xfer(6'b000101, 8'h3C, 14, g, a8);
    chk_cfg("R2 only addressed registers changed");
  endtask

  task automatic t_read();
    logic [7:0] g;
    logic a8;
    xfer(6'b110101, 8'hFF, 14, g, a8);
    chk_cfg("R3 read word dummy byte not written");
    xfer(6'b010101, 8'h77, 14, g, a8);
    chk8("R4 read-back of index 21", g, 8'hA5);
    chk8("R4 pin back to pdata after eighth fall", {7'd0, a8}, 8'h01);
    chk_cfg("R3 second read word changes nothing");
    xfer(6'b000000, 8'h00, 14, g, a8);
    chk8("R4 read-back of index 5 (a5 clear)", g, 8'h3C);
  endtask

  task automatic t_overlap();
    logic [7:0] g;
    logic a8;
    xfer(6'b110101, 8'h00, 14, g, a8);
    xfer(6'b100101, 8'h5A, 14, g, a8);
    chk8("R5 captured byte survives write to same register", g, 8'hA5);
    chk8("R5 overlapped write landed", cfg_flat[21*8 +: 8], 8'h5A);
    xfer(6'b110101, 8'h00, 14, g, a8);
    xfer(6'b000000, 8'h00, 14, g, a8);
    chk8("R5 new value read back next time", g, 8'h5A);
  endtask

  task automatic t_oe();
    oe_n = 1'b1;
    @(negedge clk);
    chk8("R6 pin disabled with oe_n high", {7'd0, pin_oe}, 8'h00);
    oe_n = 1'b0;
    @(negedge clk);
    chk8("R6 pin enabled with oe_n low", {7'd0, pin_oe}, 8'h01);
  endtask

  task automatic t_pd();
    logic [7:0] g;
    logic a8;
    xfer(6'b000110, 8'h01, 14, g, a8);
    xfer(6'b110101, 8'h00, 14, g, a8);
    xfer(6'b000110, 8'h00, 14, g, a8);
    chk8("R7 power-down keeps pdata on pin", g, 8'hFF);
    xfer(6'b110101, 8'h00, 14, g, a8);
    xfer(6'b000000, 8'h00, 14, g, a8);
    chk8("R7 read-back restored after power-down cleared", g, 8'h5A);
  endtask

  task automatic t_badcount();
    logic [7:0] g;
    logic a8;
    xfer(6'b000011, 8'hFF, 13, g, a8);
    chk_cfg("R9 13-bit word dropped");
    xfer(6'b000011, 8'hFF, 15, g, a8);
    chk_cfg("R9 15-bit word dropped");
    xfer(6'b000011, 8'hC3, 14, g, a8);
    chk8("R9 count restarts after dropped word", cfg_flat[3*8 +: 8], 8'hC3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    rst_n = 1'b0; sck = 1'b0; sdi = 1'b0; load = 1'b0;
    oe_n = 1'b0; pdata_bit = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_overlap();
    t_oe();
    t_pd();
    t_badcount();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule